// File: doc/BRIEF.md
# Crystal PLL Calibration and Relock Controller

This block is the digital controller that sits next to a crystal-based PLL. It chooses the 4-bit centre-frequency code driven into the oscillator. After reset it sweeps the code upward from zero. It holds each code for a fixed dwell time and checks a lock indication at the end of the dwell. It keeps the first code at which the loop reports lock. If no code locks, the sweep wraps around and tries again.

A bypass input takes the search out of the path and drives a user-supplied code straight to the oscillator. A relock policy input decides what happens when lock is lost. With relock enabled, a fresh sweep starts. With relock disabled, the current code is kept. The raw lock indication is debounced so that short dropouts are ignored.

The sweep state (phase, code, dwell counter) is held in three copies and read through a bitwise majority vote. A single corrupted copy therefore never reaches the outputs. It is rewritten on the next clock, and an upset flag reports the disagreement while it lasts.

Top module: `pllcal_ctrl`

## Requirements
- R1: A synchronous active-high reset drives vco_code to 0, locked to 0 and upset to 0, and leaves the controller ready to sweep from code 0.
- R2: While sweeping, each code is held for exactly SETTLE_N clock cycles (default 256). Without lock, the code then rises by one.
- R3: Lock is judged from the filtered lock state in the last cycle of a dwell. The first code judged locked is kept, and the sweep stops.
- R4: If no code locks, the code wraps from 15 back to 0 and the sweep continues with locked low.
- R5: The filtered lock state rises one cycle after lock_raw is high. It falls only after lock_raw has been sampled low on DROP_N consecutive cycles (default 4). Shorter dropouts leave it high.
- R6: With relock_en=1, bypass off and the code held, a fall of the filtered lock state restarts the sweep at code 0 on the next cycle.
- R7: With relock_en=0, loss of lock leaves the held code unchanged. No new sweep starts until reset or until bypass is released.
- R8: With bypass_en=1, vco_code equals bypass_code one cycle later, and the sweep is suspended.
- R9: With bypass_en=0, bypass_code has no effect on vco_code.
- R10: When bypass_en returns to 0, a new sweep starts at code 0 with full dwell timing.
- R11: locked always reports the filtered lock state, in sweep, hold and bypass alike.
- R12: The sweep state is held in three copies read through a majority vote. An upset in any single copy changes neither vco_code nor locked, and the bad copy is rewritten on the next clock.
- R13: upset goes high one cycle after the copies disagree and returns low once they have agreed for a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass_en | input | 1 | 1: drive bypass_code to the oscillator, no search |
| bypass_code | input | CODE_W | User centre-frequency code used in bypass |
| relock_en | input | 1 | 1: loss of lock starts a new sweep |
| lock_raw | input | 1 | Raw lock indication from the lock detector |
| vco_code | output | CODE_W | Registered centre-frequency code |
| locked | output | 1 | Filtered lock state |
| upset | output | 1 | High while the redundant copies disagreed last cycle |

## Verification
Some properties are checked on every cycle by the assertions. These are the step-or-hold rule during a dwell, holding the code once locked, the one-cycle bypass path, the restart to code 0 on relock, staying in hold when relock is off, the debounce edges, and self-healing of the redundant copies. Other behaviour only the bench scenarios can show. These are the dwell length, the choice of the first locking code for every possible code, the wrap-around when no code locks, the exact dropout length that counts as unlock, restarting after bypass is released, and outputs that stay unchanged while each of the three copies is upset in turn.

// File: rtl/pllcal_pkg.sv
package pllcal_pkg;
  // Phase of the search controller
  typedef enum logic {
    PH_SWEEP = 1'b0,
    PH_HOLD  = 1'b1
  } phase_e;
endpackage

// File: rtl/pllcal_lockfilt.sv
module pllcal_lockfilt #(
  parameter int DROP_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_raw,
  output logic lock_flt
);
  localparam int CW = $clog2(DROP_N + 1);

  logic [CW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt   <= '0;
      lock_flt <= 1'b0;
    end else if (lock_raw) begin
      lo_cnt   <= '0;
      lock_flt <= 1'b1;
    end else begin
      if (lo_cnt != CW'(DROP_N)) lo_cnt <= lo_cnt + 1'b1;
      if (lo_cnt >= CW'(DROP_N - 1)) lock_flt <= 1'b0;
    end
  end

  // R5: a high sample always yields lock next cycle
  p_rise_r5: assert property (@(posedge clk) disable iff (rst)
    lock_raw |=> lock_flt);
  // R5: lock can only drop right after a low sample
  p_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_flt) |-> $past(!lock_raw));
endmodule

// File: rtl/pllcal_tmr.sv
module pllcal_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         upset
);
  logic [W-1:0] cp0, cp1, cp2;
  logic         mismatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      cp0 <= '0;
      cp1 <= '0;
      cp2 <= '0;
    end else begin
      cp0 <= d;
      cp1 <= d;
      cp2 <= d;
    end
  end

  assign q        = (cp0 & cp1) | (cp0 & cp2) | (cp1 & cp2);
  assign mismatch = (cp0 != cp1) || (cp1 != cp2) || (cp0 != cp2);

  always_ff @(posedge clk) begin
    if (rst) upset <= 1'b0;
    else     upset <= mismatch;
  end

  // R12: every copy is rewritten from the vote, so disagreement heals in one cycle
  p_heal_r12: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> !mismatch);
  // R13: flag is clear once copies have agreed for two samples
  p_flag_clear_r13: assert property (@(posedge clk) disable iff (rst)
    (!mismatch && $past(!mismatch)) |-> !upset);
endmodule

// File: rtl/pllcal_seq.sv
module pllcal_seq
  import pllcal_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SETTLE_N = 256,
  parameter int CNT_W    = 8
) (
  input  phase_e              cur_ph,
  input  logic [CODE_W-1:0]   cur_code,
  input  logic [CNT_W-1:0]    cur_cnt,
  input  logic                lock_flt,
  input  logic                bypass_en,
  input  logic                relock_en,
  output phase_e              nxt_ph,
  output logic [CODE_W-1:0]   nxt_code,
  output logic [CNT_W-1:0]    nxt_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_N - 1);

  always_comb begin
    nxt_ph   = cur_ph;
    nxt_code = cur_code;
    nxt_cnt  = cur_cnt;
    if (bypass_en) begin
      nxt_ph   = PH_SWEEP;
      nxt_code = '0;
      nxt_cnt  = '0;
    end else begin
      unique case (cur_ph)
        PH_SWEEP: begin
          if (cur_cnt == LAST) begin
            nxt_cnt = '0;
            if (lock_flt) nxt_ph = PH_HOLD;
            else          nxt_code = cur_code + 1'b1;
          end else begin
            nxt_cnt = cur_cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (!lock_flt && relock_en) begin
            nxt_ph   = PH_SWEEP;
            nxt_code = '0;
            nxt_cnt  = '0;
          end
        end
        default: nxt_ph = PH_SWEEP;
      endcase
    end
  end
endmodule

// File: rtl/pllcal_ctrl.sv
module pllcal_ctrl
  import pllcal_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SETTLE_N = 256,
  parameter int DROP_N   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_en,
  input  logic [CODE_W-1:0] bypass_code,
  input  logic              relock_en,
  input  logic              lock_raw,
  output logic [CODE_W-1:0] vco_code,
  output logic              locked,
  output logic              upset
);
  localparam int CNT_W = (SETTLE_N > 1) ? $clog2(SETTLE_N) : 1;
  localparam int ST_W  = 1 + CODE_W + CNT_W;

  logic              lock_flt;
  logic [ST_W-1:0]   st_q, st_d;
  logic              cur_ph_b;
  phase_e            cur_ph, nxt_ph;
  logic [CODE_W-1:0] cur_code, nxt_code;
  logic [CNT_W-1:0]  cur_cnt, nxt_cnt;

  pllcal_lockfilt #(.DROP_N(DROP_N)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .lock_raw (lock_raw),
    .lock_flt (lock_flt)
  );

  pllcal_tmr #(.W(ST_W)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .d     (st_d),
    .q     (st_q),
    .upset (upset)
  );

  assign {cur_ph_b, cur_code, cur_cnt} = st_q;
  assign cur_ph = phase_e'(cur_ph_b);

  pllcal_seq #(
    .CODE_W   (CODE_W),
    .SETTLE_N (SETTLE_N),
    .CNT_W    (CNT_W)
  ) u_seq (
    .cur_ph    (cur_ph),
    .cur_code  (cur_code),
    .cur_cnt   (cur_cnt),
    .lock_flt  (lock_flt),
    .bypass_en (bypass_en),
    .relock_en (relock_en),
    .nxt_ph    (nxt_ph),
    .nxt_code  (nxt_code),
    .nxt_cnt   (nxt_cnt)
  );

  assign st_d   = {nxt_ph, nxt_code, nxt_cnt};
  assign locked = lock_flt;

  always_ff @(posedge clk) begin
    if (rst)            vco_code <= '0;
    else if (bypass_en) vco_code <= bypass_code;
    else                vco_code <= nxt_code;
  end

  // R8: bypass path is one register deep
  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    bypass_en |=> (vco_code == $past(bypass_code)));
  // R2: within a dwell the driven code does not move
  p_dwell_r2: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == PH_SWEEP && !bypass_en && cur_cnt != CNT_W'(SETTLE_N - 1))
      |=> (vco_code == $past(cur_code)));
  // R3: a held code stays put while lock persists
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == PH_HOLD && !bypass_en && lock_flt)
      |=> (vco_code == $past(cur_code)));
  // R6: loss of lock with relock restarts at code 0
  p_relock_r6: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == PH_HOLD && !bypass_en && relock_en && !lock_flt)
      |=> (vco_code == '0 && cur_ph == PH_SWEEP));
  // R7: without relock the hold phase is never left
  p_norelock_r7: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == PH_HOLD && !bypass_en && !relock_en)
      |=> (cur_ph == PH_HOLD && $stable(vco_code)));
endmodule

// File: tb/tb_pllcal_ctrl.sv
module tb_pllcal_ctrl;
  localparam int CODE_W   = 4;
  localparam int SETTLE_N = 16;
  localparam int DROP_N   = 4;
  localparam int NCODES   = 1 << CODE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bypass_en = 1'b0;
  logic [CODE_W-1:0] bypass_code = '0;
  logic              relock_en = 1'b1;
  logic              lock_raw;
  logic [CODE_W-1:0] vco_code;
  logic              locked;
  logic              upset;

  // PLL model: locks only at one target code, or a fixed override level
  logic              model_on = 1'b0;
  logic              force_lvl = 1'b0;
  logic [CODE_W-1:0] target = '0;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  assign lock_raw = model_on ? (vco_code == target) : force_lvl;

  pllcal_ctrl #(
    .CODE_W   (CODE_W),
    .SETTLE_N (SETTLE_N),
    .DROP_N   (DROP_N)
  ) dut (
    .clk         (clk),
    .rst         (rst),
    .bypass_en   (bypass_en),
    .bypass_code (bypass_code),
    .relock_en   (relock_en),
    .lock_raw    (lock_raw),
    .vco_code    (vco_code),
    .locked      (locked),
    .upset       (upset)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic check_still(input string req, input int code);
    chk(req, int'(vco_code), code);
    chk(req, int'(locked), 1);
  endtask

  initial begin
    #(4 * 100000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    rst = 1'b1;
    step(2);
    chk("R1 code", int'(vco_code), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 upset", int'(upset), 0);

    // R2/R3: every possible locking code
    for (int t = 0; t < NCODES; t++) begin
      model_on = 1'b1;
      target   = CODE_W'(t);
      relock_en = 1'b1;
      do_reset();
      if (t > 0) begin
        step(t * SETTLE_N - 1);
        chk("R2 before step", int'(vco_code), t - 1);
        chk("R2 unlocked", int'(locked), 0);
        step(1);
      end
      chk("R2 step", int'(vco_code), t);
      step(1);
      chk("R5 rise", int'(locked), 1);
      step(2 * SETTLE_N);
      chk("R3 kept code", int'(vco_code), t);
      chk("R3 locked", int'(locked), 1);
    end

    // R4: no code locks, wrap-around
    model_on = 1'b0;
    force_lvl = 1'b0;
    do_reset();
    step(NCODES * SETTLE_N - 1);
    chk("R4 last code", int'(vco_code), NCODES - 1);
    step(1);
    chk("R4 wrap", int'(vco_code), 0);
    chk("R4 locked low", int'(locked), 0);
    step(SETTLE_N);
    chk("R4 continues", int'(vco_code), 1);

    // R5/R6: dropouts and relock
    model_on = 1'b1;
    target = 4'd5;
    relock_en = 1'b1;
    do_reset();
    step(6 * SETTLE_N + 2);
    check_still("R3 locked at 5", 5);
    model_on = 1'b0;
    force_lvl = 1'b0;
    step(DROP_N - 1);
    model_on = 1'b1;
    chk("R5 short dropout", int'(locked), 1);
    step(1);
    check_still("R5 short dropout hold", 5);
    model_on = 1'b0;
    step(DROP_N - 1);
    chk("R5 before fall", int'(locked), 1);
    step(1);
    chk("R5 fall", int'(locked), 0);
    chk("R5 code at fall", int'(vco_code), 5);
    step(1);
    chk("R6 restart", int'(vco_code), 0);
    model_on = 1'b1;
    step(5 * SETTLE_N);
    chk("R6 resweep", int'(vco_code), 5);
    step(SETTLE_N + 2);
    check_still("R6 relocked", 5);

    // R7/R9/R11: relock disabled, bypass_code ignored
    relock_en = 1'b0;
    model_on = 1'b0;
    step(10);
    chk("R7 code held", int'(vco_code), 5);
    chk("R11 unlocked", int'(locked), 0);
    model_on = 1'b1;
    step(2);
    check_still("R11 relock reported", 5);
    bypass_code = 4'd9;
    step(3);
    chk("R9 ignored", int'(vco_code), 5);

    // R12/R13: upset each redundant copy
    relock_en = 1'b1;
    force dut.u_tmr.cp0 = '1;
    #1 release dut.u_tmr.cp0;
    step(1);
    chk("R13 flag copy0", int'(upset), 1);
    check_still("R12 copy0", 5);
    step(1);
    chk("R13 clear copy0", int'(upset), 0);
    check_still("R12 after copy0", 5);
    force dut.u_tmr.cp1 = '1;
    #1 release dut.u_tmr.cp1;
    step(1);
    chk("R13 flag copy1", int'(upset), 1);
    check_still("R12 copy1", 5);
    step(1);
    chk("R13 clear copy1", int'(upset), 0);
    force dut.u_tmr.cp2 = '1;
    #1 release dut.u_tmr.cp2;
    step(1);
    chk("R13 flag copy2", int'(upset), 1);
    check_still("R12 copy2", 5);
    step(1);
    chk("R13 clear copy2", int'(upset), 0);
    check_still("R12 after copy2", 5);

    // R8/R11: bypass over all codes
    bypass_en = 1'b1;
    for (int v = 0; v < NCODES; v++) begin
      bypass_code = CODE_W'(v);
      step(1);
      chk("R8 bypass code", int'(vco_code), v);
      step(DROP_N + 1);
      chk("R11 bypass locked", int'(locked), (v == 5) ? 1 : 0);
    end

    // R10: release of bypass starts a fresh sweep
    bypass_en = 1'b0;
    step(1);
    chk("R10 start", int'(vco_code), 0);
    step(5 * SETTLE_N - 1);
    chk("R10 sweep", int'(vco_code), 5);
    step(SETTLE_N + 2);
    check_still("R10 locked", 5);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule